// File: doc/BRIEF.md
# Protected Command Decoder for a NOR Flash Bank

This block is the device side of a parallel NOR flash bank's write-protected command interface. A host issues single-cycle synchronous write strobes carrying an address and a data word. The block decodes the unlock handshakes that guard every change to the array: word program, chip erase, sector erase, block erase, identification entry and identification exit. An accepted program or erase starts an internal operation. That operation keeps the bank busy for a programmable number of clock cycles, which stand in for the analog program and erase times.

While the bank is busy, every read returns a status word in place of array data. Bit 7 is a polling flag. Bit 6 is a toggle flag that changes on each read. All other bits are zero. Every command write is ignored until the operation finishes. In identification mode, reads return a manufacturer code and a device code.

The array is a small register file. It holds the lowest `2**WORD_IDX_W` words of each of the first `2**SEC_IDX_W` sectors. Other addresses alias onto these words, so the sector and block geometry can be exercised without full-size storage.

Top module: `fcmd_top`

## Requirements
- R1: After reset, busy is low, rdata is zero, and every stored word reads 16'hFFFF.
- R2: The two unlock writes are 8'hAA to 5555H and then 8'h55 to 2AAAH. Command addresses are compared on address bits 14..0 only, and data bits 15..8 of every command write are ignored.
- R3: After the unlock pair, 8'hA0 to 5555H arms a program. The next write, at any address, replaces the addressed word with the old word ANDed with the written data, so a 0 bit never returns to 1.
- R4: busy rises on the edge that accepts the final write of a program or erase. It stays high for exactly PROG_CYCLES clock cycles (program), ERASE_CYCLES (sector or block erase) or CHIP_CYCLES (chip erase).
- R5: rdata is a register. It is loaded on every clock edge where rd_en is high and holds its value otherwise. When idle and not in identification mode, it loads the addressed array word.
- R6: A read while busy loads a status word. Bit 7 is the inverse of bit 7 of the programmed data, or 0 during an erase. Bit 6 is 0 on the first read after the operation starts and inverts on each later read. All other bits are 0.
- R7: The unlock pair, 8'h80 to 5555H, the unlock pair again, then 8'h10 to 5555H erases every word to all ones.
- R8: The same prefix ending with 8'h30 erases the sector selected by address bits 20..11, a sector being 2K words.
- R9: The same prefix ending with 8'h50 erases the block selected by address bits 20..15, a block being 32K words.
- R10: Any write that does not match the next expected step returns the decoder to its first step and is not itself re-examined. An aborted sequence changes no word and does not raise busy.
- R11: The unlock pair followed by 8'h90 to 5555H enters identification mode. There, reads of address 0 return 16'h00BF, reads of address 1 return 16'h2783, and reads of any other address return 0.
- R12: Identification mode is left either by a single 8'hF0 write at any address when no sequence is in progress, or by the unlock pair followed by 8'hF0 to 5555H. Reads then return array data.
- R13: While busy, every write is ignored, including the unlock, identification entry and exit, and program sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Word address shared by reads and writes |
| wdata | input | DATA_W | Write data or command byte in bits 7..0 |
| rdata | output | DATA_W | Registered read data or status word |
| busy | output | 1 | High while an internal program or erase runs |

## Verification
A read is due one clock after its strobe, because rdata is loaded on the strobe's own edge. busy is high from the edge that takes the last command write, and it is expected for exactly the configured number of cycles. The bench counts those cycles one falling edge at a time. An erase or program result shows up on the first read issued after busy falls. Inputs change and outputs are sampled only on falling edges, and a behavioural model advanced on each rising edge predicts rdata and busy, which are compared at every falling edge.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

   // Command addresses are matched on this many low address bits.
   localparam int CMD_ADDR_W = 15;
   localparam logic [CMD_ADDR_W-1:0] UNLOCK_ADDR_1 = 15'h5555;
   localparam logic [CMD_ADDR_W-1:0] UNLOCK_ADDR_2 = 15'h2AAA;

   localparam logic [7:0] CB_UNLOCK_1 = 8'hAA;
   localparam logic [7:0] CB_UNLOCK_2 = 8'h55;
   localparam logic [7:0] CB_PROGRAM  = 8'hA0;
   localparam logic [7:0] CB_ERASE    = 8'h80;
   localparam logic [7:0] CB_ID_ENTER = 8'h90;
   localparam logic [7:0] CB_ID_LEAVE = 8'hF0;
   localparam logic [7:0] CB_CHIP     = 8'h10;
   localparam logic [7:0] CB_SECTOR   = 8'h30;
   localparam logic [7:0] CB_BLOCK    = 8'h50;

   typedef enum logic [2:0] {
      SQ_IDLE,    // waiting for first unlock write
      SQ_UNL,     // waiting for second unlock write
      SQ_CMD,     // waiting for command byte
      SQ_PROG,    // next write is the program word
      SQ_EUNL1,   // erase: waiting for first unlock again
      SQ_EUNL2,   // erase: waiting for second unlock again
      SQ_ESEL     // erase: waiting for erase kind
   } seq_state_t;

   typedef enum logic [1:0] {
      OP_PROG,
      OP_SECT,
      OP_BLK,
      OP_CHIP
   } op_kind_t;

endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
   import fcmd_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  busy,
   input  logic [CMD_ADDR_W-1:0] cmd_addr,
   input  logic [7:0]            cmd_byte,
   output logic                  op_start,
   output op_kind_t              op_kind,
   output logic                  id_mode
);

   seq_state_t state_q, state_d;
   logic       id_d;
   logic       at_a1, at_a2;

   assign at_a1 = (cmd_addr == UNLOCK_ADDR_1);
   assign at_a2 = (cmd_addr == UNLOCK_ADDR_2);

   always_comb begin
      state_d  = state_q;
      id_d     = id_mode;
      op_start = 1'b0;
      op_kind  = OP_PROG;
      if (wr_en && !busy) begin
         state_d = SQ_IDLE;
         case (state_q)
            SQ_IDLE: begin
               if (at_a1 && cmd_byte == CB_UNLOCK_1) state_d = SQ_UNL;
               else if (cmd_byte == CB_ID_LEAVE)     id_d    = 1'b0;
            end
            SQ_UNL: begin
               if (at_a2 && cmd_byte == CB_UNLOCK_2) state_d = SQ_CMD;
            end
            SQ_CMD: begin
               if (at_a1) begin
                  case (cmd_byte)
                     CB_PROGRAM:  state_d = SQ_PROG;
                     CB_ERASE:    state_d = SQ_EUNL1;
                     CB_ID_ENTER: id_d    = 1'b1;
                     CB_ID_LEAVE: id_d    = 1'b0;
                     default:     state_d = SQ_IDLE;
                  endcase
               end
            end
            SQ_PROG: begin
               op_start = 1'b1;
               op_kind  = OP_PROG;
            end
            SQ_EUNL1: begin
               if (at_a1 && cmd_byte == CB_UNLOCK_1) state_d = SQ_EUNL2;
            end
            SQ_EUNL2: begin
               if (at_a2 && cmd_byte == CB_UNLOCK_2) state_d = SQ_ESEL;
            end
            SQ_ESEL: begin
               if (at_a1 && cmd_byte == CB_CHIP) begin
                  op_start = 1'b1;
                  op_kind  = OP_CHIP;
               end else if (cmd_byte == CB_SECTOR) begin
                  op_start = 1'b1;
                  op_kind  = OP_SECT;
               end else if (cmd_byte == CB_BLOCK) begin
                  op_start = 1'b1;
                  op_kind  = OP_BLK;
               end
            end
            default: state_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         id_mode <= 1'b0;
      end else begin
         state_q <= state_d;
         id_mode <= id_d;
      end
   end

endmodule

// File: rtl/fcmd_busy.sv
module fcmd_busy
   import fcmd_pkg::*;
#(
   parameter int PROG_CYCLES  = 350,
   parameter int ERASE_CYCLES = 900_000,
   parameter int CHIP_CYCLES  = 2_000_000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  op_kind_t kind,
   input  logic     prog_bit7,
   input  logic     rd_en,
   output logic     busy,
   output logic     poll_bit,
   output logic     toggle_bit
);

   localparam int MAX_PE  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int MAX_CYC = (MAX_PE > CHIP_CYCLES) ? MAX_PE : CHIP_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1 || CHIP_CYCLES < 1) begin : g_bad_cycles
      $error("fcmd_busy: every operation needs at least one busy cycle");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load;

   if (PROG_CYCLES == ERASE_CYCLES && ERASE_CYCLES == CHIP_CYCLES) begin : g_uniform
      assign load = CNT_W'(PROG_CYCLES);
   end else begin : g_mixed
      always_comb begin
         case (kind)
            OP_PROG: load = CNT_W'(PROG_CYCLES);
            OP_CHIP: load = CNT_W'(CHIP_CYCLES);
            default: load = CNT_W'(ERASE_CYCLES);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         poll_bit   <= 1'b0;
         toggle_bit <= 1'b0;
      end else if (start) begin
         cnt_q      <= load;
         poll_bit   <= (kind == OP_PROG) ? ~prog_bit7 : 1'b0;
         toggle_bit <= 1'b0;
      end else begin
         if (cnt_q != '0)     cnt_q      <= cnt_q - 1'b1;
         if (rd_en && busy)   toggle_bit <= ~toggle_bit;
      end
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
   import fcmd_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int SEC_IDX_W  = 5,
   parameter int WORD_IDX_W = 2,
   parameter int BLK_IDX_W  = 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  op_kind_t                        kind,
   input  logic [SEC_IDX_W+WORD_IDX_W-1:0] word_sel,
   input  logic [SEC_IDX_W-1:0]            sect_sel,
   input  logic [BLK_IDX_W-1:0]            blk_sel,
   input  logic [DATA_W-1:0]               wdata,
   output logic [DATA_W-1:0]               rd_word
);

   localparam int IDX_W = SEC_IDX_W + WORD_IDX_W;
   localparam int WORDS = 1 << IDX_W;

   if (BLK_IDX_W < 1 || BLK_IDX_W > SEC_IDX_W) begin : g_bad_geom
      $error("fcmd_array: block index must be narrower than sector index");
   end

   logic [DATA_W-1:0] word_view [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [IDX_W-1:0]     MY_IDX = IDX_W'(w);
      localparam logic [SEC_IDX_W-1:0] MY_SEC = MY_IDX[IDX_W-1:WORD_IDX_W];
      logic [DATA_W-1:0] word_q;
      logic              erase_hit;

      always_comb begin
         case (kind)
            OP_SECT: erase_hit = (MY_SEC == sect_sel);
            OP_BLK:  erase_hit = (MY_SEC[SEC_IDX_W-1 -: BLK_IDX_W] == blk_sel);
            OP_CHIP: erase_hit = 1'b1;
            default: erase_hit = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '1;
         end else if (start) begin
            if (kind == OP_PROG) begin
               if (word_sel == MY_IDX) word_q <= word_q & wdata;
            end else if (erase_hit) begin
               word_q <= '1;
            end
         end
      end

      assign word_view[w] = word_q;
   end

   assign rd_word = word_view[word_sel];

endmodule

// File: rtl/fcmd_top.sv
module fcmd_top
   import fcmd_pkg::*;
#(
   parameter int                 ADDR_W       = 21,
   parameter int                 DATA_W       = 16,
   parameter int                 SECTOR_LG    = 11,
   parameter int                 BLOCK_LG     = 15,
   parameter int                 SEC_IDX_W    = 5,
   parameter int                 WORD_IDX_W   = 2,
   parameter int                 PROG_CYCLES  = 350,
   parameter int                 ERASE_CYCLES = 900_000,
   parameter int                 CHIP_CYCLES  = 2_000_000,
   parameter logic [DATA_W-1:0]  MFR_CODE     = DATA_W'(16'h00BF),
   parameter logic [DATA_W-1:0]  DEV_CODE     = DATA_W'(16'h2783)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              busy
);

   localparam int SPB_LG    = BLOCK_LG - SECTOR_LG;
   localparam int BLK_IDX_W = SEC_IDX_W - SPB_LG;
   localparam int IDX_W     = SEC_IDX_W + WORD_IDX_W;
   localparam int MAX_PE    = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int MAX_CYCLES = (MAX_PE > CHIP_CYCLES) ? MAX_PE : CHIP_CYCLES;

   if (DATA_W < 8)                          begin : g_bad_data
      $error("fcmd_top: data bus must carry a command byte");
   end
   if (ADDR_W < CMD_ADDR_W)                 begin : g_bad_addr
      $error("fcmd_top: address bus narrower than command address");
   end
   if (SPB_LG < 1 || BLK_IDX_W < 1)         begin : g_bad_block
      $error("fcmd_top: block must span several modelled sectors");
   end
   if (SECTOR_LG + SEC_IDX_W > ADDR_W)      begin : g_bad_sector
      $error("fcmd_top: sector index exceeds address bus");
   end
   if (WORD_IDX_W > SECTOR_LG)              begin : g_bad_word
      $error("fcmd_top: word index exceeds sector size");
   end

   logic                 op_start;
   op_kind_t             op_kind;
   logic                 id_mode;
   logic                 poll_bit, toggle_bit;
   logic [DATA_W-1:0]    array_word;
   logic [DATA_W-1:0]    rd_next;
   logic [IDX_W-1:0]     word_sel;

   assign word_sel = {addr[SECTOR_LG +: SEC_IDX_W], addr[WORD_IDX_W-1:0]};

   fcmd_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .busy     (busy),
      .cmd_addr (addr[CMD_ADDR_W-1:0]),
      .cmd_byte (wdata[7:0]),
      .op_start (op_start),
      .op_kind  (op_kind),
      .id_mode  (id_mode)
   );

   fcmd_busy #(
      .PROG_CYCLES  (PROG_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES),
      .CHIP_CYCLES  (CHIP_CYCLES)
   ) u_busy (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (op_start),
      .kind       (op_kind),
      .prog_bit7  (wdata[7]),
      .rd_en      (rd_en),
      .busy       (busy),
      .poll_bit   (poll_bit),
      .toggle_bit (toggle_bit)
   );

   fcmd_array #(
      .DATA_W     (DATA_W),
      .SEC_IDX_W  (SEC_IDX_W),
      .WORD_IDX_W (WORD_IDX_W),
      .BLK_IDX_W  (BLK_IDX_W)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (op_start),
      .kind     (op_kind),
      .word_sel (word_sel),
      .sect_sel (addr[SECTOR_LG +: SEC_IDX_W]),
      .blk_sel  (addr[BLOCK_LG +: BLK_IDX_W]),
      .wdata    (wdata),
      .rd_word  (array_word)
   );

   always_comb begin
      rd_next = '0;
      if (busy) begin
         rd_next[7] = poll_bit;
         rd_next[6] = toggle_bit;
      end else if (id_mode) begin
         if (addr == ADDR_W'(0))      rd_next = MFR_CODE;
         else if (addr == ADDR_W'(1)) rd_next = DEV_CODE;
      end else begin
         rd_next = array_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
   parameter int                ADDR_W   = 21,
   parameter int                DATA_W   = 16,
   parameter int                MAX_CYC  = 2_000_000,
   parameter logic [DATA_W-1:0] MFR_CODE = DATA_W'(16'h00BF)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic              busy,
   input logic              op_start,
   input logic              id_mode
);

   localparam logic [DATA_W-1:0] STATUS_MASK = DATA_W'(8'hC0);

   int run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else           run_len <= 0;
   end

   // R4: a busy stretch never outlasts the longest configured operation
   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len < MAX_CYC));

   // R4: an accepted operation raises busy on the next sample
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> busy);

   // R13: no operation is launched while one is running
   p_no_start_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !op_start);

   // R6: a status read carries only the two flag bits
   p_status_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_en) |=> ((rdata & ~STATUS_MASK) == '0));

   // R6: back-to-back status reads alternate the toggle flag
   p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_en && $past(busy && rd_en)) |=> (rdata[6] != $past(rdata[6])));

   // R11: identification read of address zero yields the manufacturer code
   p_id_mfr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && id_mode && rd_en && addr == ADDR_W'(0)) |=> (rdata == MFR_CODE));

endmodule

bind fcmd_top fcmd_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .MAX_CYC  (MAX_CYCLES),
   .MFR_CODE (MFR_CODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .addr     (addr),
   .rdata    (rdata),
   .busy     (busy),
   .op_start (op_start),
   .id_mode  (id_mode)
);

// File: tb/fcmd_top_tb_top.sv
module fcmd_top_tb_top;

   localparam int P_CYC = 6;
   localparam int E_CYC = 9;
   localparam int C_CYC = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [20:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        busy;

   int    n_chk = 0;
   int    n_err = 0;
   bit    done = 1'b0;
   bit    live = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   fcmd_top #(
      .PROG_CYCLES  (P_CYC),
      .ERASE_CYCLES (E_CYC),
      .CHIP_CYCLES  (C_CYC)
   ) dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .busy  (busy)
   );

   // ---------------- behavioural reference ----------------
   logic [15:0] m_mem [128];
   logic [15:0] m_rdata;
   int          m_busy;
   int          m_st;
   bit          m_id, m_dq7, m_tog;

   function automatic int mi(logic [20:0] a);
      return int'({a[15:11], a[1:0]});
   endfunction

   task automatic m_write(logic [20:0] a, logic [15:0] d);
      bit          a1 = (a[14:0] == 15'h5555);
      bit          a2 = (a[14:0] == 15'h2AAA);
      logic [7:0]  c  = d[7:0];
      int          ns = 0;
      case (m_st)
         0: if (a1 && c == 8'hAA) ns = 1; else if (c == 8'hF0) m_id = 0;
         1: if (a2 && c == 8'h55) ns = 2;
         2: if (a1) begin
               if (c == 8'hA0) ns = 3;
               else if (c == 8'h80) ns = 4;
               else if (c == 8'h90) m_id = 1;
               else if (c == 8'hF0) m_id = 0;
            end
         3: begin
               m_mem[mi(a)] = m_mem[mi(a)] & d;
               m_busy = P_CYC; m_dq7 = ~d[7]; m_tog = 0;
            end
         4: if (a1 && c == 8'hAA) ns = 5;
         5: if (a2 && c == 8'h55) ns = 6;
         6: begin
               if (a1 && c == 8'h10) begin
                  for (int i = 0; i < 128; i++) m_mem[i] = 16'hFFFF;
                  m_busy = C_CYC; m_dq7 = 0; m_tog = 0;
               end else if (c == 8'h30) begin
                  for (int i = 0; i < 128; i++)
                     if ((i >> 2) == int'(a[15:11])) m_mem[i] = 16'hFFFF;
                  m_busy = E_CYC; m_dq7 = 0; m_tog = 0;
               end else if (c == 8'h50) begin
                  for (int i = 0; i < 128; i++)
                     if ((i >> 6) == int'(a[15])) m_mem[i] = 16'hFFFF;
                  m_busy = E_CYC; m_dq7 = 0; m_tog = 0;
               end
            end
         default: ns = 0;
      endcase
      m_st = ns;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) m_mem[i] = 16'hFFFF;
         m_rdata = '0; m_busy = 0; m_st = 0; m_id = 0; m_dq7 = 0; m_tog = 0;
      end else begin
         bit pre_busy;
         pre_busy = (m_busy != 0);
         if (rd_en) begin
            if (pre_busy)           m_rdata = {8'h00, m_dq7, m_tog, 6'b0};
            else if (m_id)          m_rdata = (addr == 0) ? 16'h00BF : (addr == 1) ? 16'h2783 : 16'h0000;
            else                    m_rdata = m_mem[mi(addr)];
            if (pre_busy) m_tog = ~m_tog;
         end
         if (m_busy > 0) m_busy--;
         if (wr_en && !pre_busy) m_write(addr, wdata);
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (live && rst_n) begin
         chk(cur_req, 32'(rdata), 32'(m_rdata));
         chk("R4", 32'(busy), 32'(m_busy != 0));
      end
   end

   // ---------------- stimulus helpers (entered and left at a falling edge) ----------------
   task automatic wr(logic [20:0] a, logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [20:0] a);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_exp(logic [20:0] a, logic [15:0] exp, string req);
      rd(a);
      chk(req, 32'(rdata), 32'(exp));
   endtask

   task automatic unlock();
      wr(21'h05555, 16'h00AA);
      wr(21'h02AAA, 16'h0055);
   endtask

   task automatic prog(logic [20:0] a, logic [15:0] d);
      unlock();
      wr(21'h05555, 16'h00A0);
      wr(a, d);
   endtask

   task automatic erase_prefix();
      unlock();
      wr(21'h05555, 16'h0080);
      unlock();
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic measure(int exp, string req);
      int n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(req, 32'(n), 32'(exp));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (50_000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog (R4): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1", 32'(rdata), 32'h0);
      chk("R1", 32'(busy), 32'h0);
      live = 1'b1;
      rd_exp(21'h00000, 16'hFFFF, "R1");
      rd_exp(21'h1FFFFF, 16'hFFFF, "R1");

      // R2: high data byte and high address bits ignored on command writes
      cur_req = "R2";
      wr(21'h105555, 16'h12AA);
      wr(21'h0F2AAA, 16'hFF55);
      wr(21'h05555, 16'h77A0);
      cur_req = "R3";
      wr(21'h01001, 16'h1234);
      // R6: status during program: bit7 = ~0, toggle 0,1,0
      cur_req = "R6";
      rd_exp(21'h01001, 16'h0080, "R6");
      rd_exp(21'h01001, 16'h00C0, "R6");
      rd_exp(21'h01001, 16'h0080, "R6");
      wait_idle();
      cur_req = "R3";
      rd_exp(21'h01001, 16'h1234, "R3");
      // R5: rdata holds while rd_en is low
      cur_req = "R5";
      repeat (3) @(negedge clk);
      chk("R5", 32'(rdata), 32'h1234);

      // R3: second program ANDs into the word
      cur_req = "R3";
      prog(21'h01001, 16'hFF0F);
      measure(P_CYC, "R4");
      rd_exp(21'h01001, 16'h1204, "R3");

      // R10: aborted sequence
      cur_req = "R10";
      wr(21'h05555, 16'h00AA);
      wr(21'h02AAA, 16'h0056);
      wr(21'h05555, 16'h00A0);
      wr(21'h01001, 16'h0000);
      chk("R10", 32'(busy), 32'h0);
      rd_exp(21'h01001, 16'h1204, "R10");
      erase_prefix();
      wr(21'h01000, 16'h0020);
      chk("R10", 32'(busy), 32'h0);
      rd_exp(21'h01001, 16'h1204, "R10");

      // R11 / R12: identification mode
      cur_req = "R11";
      unlock();
      wr(21'h05555, 16'h0090);
      rd_exp(21'h00000, 16'h00BF, "R11");
      rd_exp(21'h00001, 16'h2783, "R11");
      rd_exp(21'h00002, 16'h0000, "R11");
      cur_req = "R12";
      wr(21'h00123, 16'h00F0);
      rd_exp(21'h01001, 16'h1204, "R12");
      unlock();
      wr(21'h05555, 16'h0090);
      rd_exp(21'h00001, 16'h2783, "R11");
      unlock();
      wr(21'h05555, 16'h00F0);
      rd_exp(21'h00000, 16'hFFFF, "R12");

      // R13: writes ignored while busy
      cur_req = "R13";
      prog(21'h01800, 16'hABCD);
      unlock();
      wr(21'h05555, 16'h0090);
      wait_idle();
      rd_exp(21'h00000, 16'hFFFF, "R13");
      rd_exp(21'h01800, 16'hABCD, "R13");
      prog(21'h01801, 16'h0F00);
      prog(21'h01801, 16'h0000);
      wait_idle();
      rd_exp(21'h01801, 16'h0F00, "R13");

      // R8: sector erase, status shows bit7 = 0
      cur_req = "R8";
      erase_prefix();
      wr(21'h01000, 16'h0030);
      rd_exp(21'h01001, 16'h0000, "R6");
      rd_exp(21'h01001, 16'h0040, "R6");
      wait_idle();
      rd_exp(21'h01001, 16'hFFFF, "R8");
      rd_exp(21'h01800, 16'hABCD, "R8");

      // R9: block erase
      cur_req = "R9";
      prog(21'h08802, 16'h5A5A);
      wait_idle();
      prog(21'h00803, 16'h0F0F);
      wait_idle();
      erase_prefix();
      wr(21'h08000, 16'h0050);
      measure(E_CYC, "R4");
      rd_exp(21'h08802, 16'hFFFF, "R9");
      rd_exp(21'h00803, 16'h0F0F, "R9");
      rd_exp(21'h01800, 16'hABCD, "R9");

      // R7: chip erase
      cur_req = "R7";
      erase_prefix();
      wr(21'h05555, 16'h0010);
      measure(C_CYC, "R4");
      rd_exp(21'h00803, 16'hFFFF, "R7");
      rd_exp(21'h01800, 16'hFFFF, "R7");
      rd_exp(21'h01801, 16'hFFFF, "R7");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule